// File: doc/BRIEF.md
# Channel Status Double Buffer

This block holds the channel status bits of a two-channel digital audio transmitter in two copies. The editable copy is 24 words of 16 bits. The upper byte of each word belongs to channel A and the lower byte to channel B. The host reads and writes the editable copy through a byte-wide register port. The transmit copy is what the serializer reads, one status bit per channel per frame. The transmit copy is refreshed from the editable copy in a single clock cycle, and only when the output time base pulses its block-boundary strobe. Because the refresh is atomic, the serializer never sees a block that is partly old and partly new.

The host can hold off the refresh with an inhibit bit while it performs long multi-register edits. A sticky completion flag tells the host that a refresh has just happened, which means the next block period is a safe window for editing. Host access works in one of two modes. In byte mode every address names one byte. In word mode an address names a word, and two consecutive accesses move its upper byte and then its lower byte. Writes to the editable copy are dropped while the block is powered down or while the master clock is reported absent.

Top module: `cs_dbuf`

## Requirements
- R1: After reset, every editable byte reads 0, both serial outputs are 0 at every frame index, and the control and status registers read 0.
- R2: In byte mode (control bit 1 clear), host address 2k reaches the channel A byte (bits 15:8) of word k and address 2k+1 reaches the channel B byte (bits 7:0), for k from 0 to 23.
- R3: In word mode (control bit 1 set), address k reaches word k. The first access after entering the mode, or after the previous word access completed, moves bits 15:8. The following access moves bits 7:0. Any access to a control or status address restarts at the upper byte.
- R4: A host write to the editable copy leaves it unchanged while the power-down bit (control bit 2) is set or while `mclk_ok` is low.
- R5: The transmit copy takes the whole editable copy on a clock edge where `blk_strobe` is high and inhibit is clear. At every other edge it is unchanged.
- R6: While the inhibit bit (control bit 0) is set, no strobe changes the transmit copy and no strobe sets the completion flag.
- R7: Each completed refresh sets status bit 0, and the bit stays set until the host reads the status address (0x41). That read returns 1 and clears the bit.
- R8: If a refresh completes in the same cycle as a status read, the read returns the old value and the flag stays set.
- R9: At frame index n < 192, `cs_a` equals bit n%8 of the transmit channel A byte of word n/8, and `cs_b` equals bit n%8 of the channel B byte of that word. For n >= 192, both outputs are 0.
- R10: A host write in the same cycle as a refresh lands in the editable copy only. The transmit copy receives the contents that the editable copy held before that write.
- R11: The control register sits at address 0x40 (bit 0 inhibit, bit 1 word mode, bit 2 power-down) and is readable and writable in every state. Read data appears on `host_rdata` one clock after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_ok | input | 1 | High while the master clock is running |
| host_wr | input | 1 | Host write request, one cycle per access |
| host_rd | input | 1 | Host read request, one cycle per access |
| host_addr | input | 7 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered |
| blk_strobe | input | 1 | Block-boundary pulse from the output time base |
| frame_idx | input | 8 | Frame index within the block, from the serializer |
| cs_a | output | 1 | Channel A status bit for the current frame |
| cs_b | output | 1 | Channel B status bit for the current frame |

## Verification
A bad byte in the editable copy shows on `host_rdata` one clock after the read that addresses it. A bad or mistimed transmit copy shows on `cs_a` or `cs_b` as soon as `frame_idx` points into the affected byte, and this holds from the first clock after the strobe. An error in the word-mode byte pointer or in the completion flag shows on the very next host read, because the wrong byte or the wrong flag value comes back. For this reason the bench sweeps every byte address and every frame index after each change of the copies.

// File: rtl/cs_dbuf_pkg.sv
package cs_dbuf_pkg;

    localparam int CS_BYTE_W  = 8;
    localparam int CS_WORD_W  = 2 * CS_BYTE_W;
    localparam int CS_ADDR_W  = 7;
    localparam logic [CS_ADDR_W-1:0] CS_CTRL_ADDR = 7'h40;
    localparam logic [CS_ADDR_W-1:0] CS_STAT_ADDR = 7'h41;

    // control register layout: bit2 power-down, bit1 word mode, bit0 inhibit
    typedef struct packed {
        logic pdn;
        logic two_byte;
        logic inhibit;
    } cs_ctrl_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_EBUF,
        ACC_CTRL,
        ACC_STAT
    } cs_acc_e;

    function automatic cs_acc_e cs_classify(input logic [CS_ADDR_W-1:0] addr,
                                            input logic two_byte,
                                            input int nwords);
        int lim;
        if (addr == CS_CTRL_ADDR) return ACC_CTRL;
        if (addr == CS_STAT_ADDR) return ACC_STAT;
        lim = two_byte ? nwords : 2 * nwords;
        if (int'(addr) < lim) return ACC_EBUF;
        return ACC_NONE;
    endfunction

endpackage

// File: rtl/cs_ebuf.sv
module cs_ebuf
    import cs_dbuf_pkg::*;
#(
    parameter int NWORDS = 24,
    localparam int WIX_W = $clog2(NWORDS)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               we,
    input  logic                               wr_ok,
    input  logic [WIX_W-1:0]                   widx,
    input  logic                               hi,
    input  logic [CS_BYTE_W-1:0]               wdata,
    output logic [NWORDS-1:0][CS_WORD_W-1:0]   e_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            e_q <= '0;
        end else if (we && wr_ok) begin
            if (hi) e_q[widx][CS_WORD_W-1:CS_BYTE_W] <= wdata;
            else    e_q[widx][CS_BYTE_W-1:0]         <= wdata;
        end
    end

    // R4: a locked buffer does not move
    p_e_locked_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_ok |=> $stable(e_q));

    p_e_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(e_q));

endmodule

// File: rtl/cs_fbuf.sv
module cs_fbuf
    import cs_dbuf_pkg::*;
#(
    parameter int NWORDS  = 24,
    parameter int FRAME_W = 8,
    localparam int NFRAMES = NWORDS * CS_BYTE_W,
    localparam int BIX_W   = $clog2(CS_BYTE_W)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             blk_strobe,
    input  logic                             inhibit,
    input  logic [NWORDS-1:0][CS_WORD_W-1:0] e_q,
    input  logic [FRAME_W-1:0]               frame_idx,
    output logic                             xfer_go,
    output logic                             cs_a,
    output logic                             cs_b
);

    logic [NWORDS-1:0][CS_WORD_W-1:0] f_q;
    logic [CS_WORD_W-1:0]             f_word;
    logic [BIX_W-1:0]                 bit_ix;
    logic                             in_range;
    logic [1:0]                       lane_bit;

    assign xfer_go = blk_strobe && !inhibit;

    always_ff @(posedge clk) begin
        if (rst)          f_q <= '0;
        else if (xfer_go) f_q <= e_q;
    end

    assign in_range = int'(frame_idx) < NFRAMES;
    assign bit_ix   = frame_idx[BIX_W-1:0];
    assign f_word   = in_range ? f_q[frame_idx[FRAME_W-1:BIX_W]] : '0;

    // lane 0 is channel A (upper byte), lane 1 is channel B (lower byte)
    for (genvar c = 0; c < 2; c++) begin : g_lane
        localparam int OFF = (1 - c) * CS_BYTE_W;
        assign lane_bit[c] = in_range && f_word[OFF + int'(bit_ix)];
    end

    assign cs_a = lane_bit[0];
    assign cs_b = lane_bit[1];

    // R5: the copy is whole and only on a permitted strobe
    p_f_copy_r5: assert property (@(posedge clk) disable iff (rst)
        xfer_go |=> f_q == $past(e_q));

    p_f_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !xfer_go |=> $stable(f_q));

    // R6: inhibit blocks the copy
    p_f_inhibit_r6: assert property (@(posedge clk) disable iff (rst)
        inhibit |=> $stable(f_q));

    // R9: outside the block both lanes are quiet
    p_f_tail_r9: assert property (@(posedge clk) disable iff (rst)
        (int'(frame_idx) >= NFRAMES) |-> !cs_a && !cs_b);

endmodule

// File: rtl/cs_host_if.sv
module cs_host_if
    import cs_dbuf_pkg::*;
#(
    parameter int NWORDS = 24,
    localparam int WIX_W = $clog2(NWORDS)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             host_wr,
    input  logic                             host_rd,
    input  logic [CS_ADDR_W-1:0]             host_addr,
    input  logic [CS_BYTE_W-1:0]             host_wdata,
    output logic [CS_BYTE_W-1:0]             host_rdata,
    input  logic                             xfer_go,
    input  logic [NWORDS-1:0][CS_WORD_W-1:0] e_q,
    output cs_ctrl_t                         ctrl,
    output logic                             e_we,
    output logic [WIX_W-1:0]                 e_widx,
    output logic                             e_hi,
    output logic [CS_BYTE_W-1:0]             e_wdata
);

    cs_acc_e              kind;
    logic                 active;
    logic                 is_rd;
    logic                 phase;
    logic                 stat_flag;
    logic [CS_WORD_W-1:0] sel_word;

    assign active  = host_wr || host_rd;
    assign is_rd   = host_rd && !host_wr;
    assign kind    = active ? cs_classify(host_addr, ctrl.two_byte, NWORDS) : ACC_NONE;

    assign e_widx  = ctrl.two_byte ? host_addr[WIX_W-1:0] : host_addr[WIX_W:1];
    assign e_hi    = ctrl.two_byte ? !phase : !host_addr[0];
    assign e_we    = host_wr && (kind == ACC_EBUF);
    assign e_wdata = host_wdata;
    assign sel_word = e_q[e_widx];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl       <= '0;
            phase      <= 1'b0;
            stat_flag  <= 1'b0;
            host_rdata <= '0;
        end else begin
            if (host_wr && kind == ACC_CTRL)
                ctrl <= cs_ctrl_t'(host_wdata[2:0]);

            if (!ctrl.two_byte)          phase <= 1'b0;
            else if (kind == ACC_EBUF)   phase <= !phase;
            else if (kind != ACC_NONE)   phase <= 1'b0;

            if (xfer_go)                             stat_flag <= 1'b1;
            else if (is_rd && kind == ACC_STAT)      stat_flag <= 1'b0;

            if (is_rd) begin
                unique case (kind)
                    ACC_EBUF: host_rdata <= e_hi ? sel_word[CS_WORD_W-1:CS_BYTE_W]
                                                 : sel_word[CS_BYTE_W-1:0];
                    ACC_CTRL: host_rdata <= {{(CS_BYTE_W-3){1'b0}}, ctrl};
                    ACC_STAT: host_rdata <= {{(CS_BYTE_W-1){1'b0}}, stat_flag};
                    default:  host_rdata <= '0;
                endcase
            end
        end
    end

    // R2: byte mode never uses the word pointer
    p_phase_byte_r2: assert property (@(posedge clk) disable iff (rst)
        !ctrl.two_byte |-> !phase);

    // R3: a control or status access restarts the word pointer
    p_phase_restart_r3: assert property (@(posedge clk) disable iff (rst)
        (kind == ACC_CTRL || kind == ACC_STAT) |=> !phase);

    // R7: completion sets the flag, a plain status read clears it
    p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
        xfer_go |=> stat_flag);

    p_flag_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (is_rd && kind == ACC_STAT && !xfer_go) |=> !stat_flag);

    // R8: the flag is sticky unless a status read takes it
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (stat_flag && !(is_rd && kind == ACC_STAT)) |=> stat_flag);

endmodule

// File: rtl/cs_dbuf.sv
module cs_dbuf
    import cs_dbuf_pkg::*;
#(
    parameter int NWORDS  = 24,
    parameter int FRAME_W = 8,
    localparam int WIX_W  = $clog2(NWORDS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mclk_ok,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [6:0]           host_addr,
    input  logic [7:0]           host_wdata,
    output logic [7:0]           host_rdata,
    input  logic                 blk_strobe,
    input  logic [FRAME_W-1:0]   frame_idx,
    output logic                 cs_a,
    output logic                 cs_b
);

    cs_ctrl_t                         ctrl;
    logic [NWORDS-1:0][CS_WORD_W-1:0] e_q;
    logic                             e_we;
    logic [WIX_W-1:0]                 e_widx;
    logic                             e_hi;
    logic [CS_BYTE_W-1:0]             e_wdata;
    logic                             xfer_go;
    logic                             wr_ok;

    assign wr_ok = mclk_ok && !ctrl.pdn;

    cs_host_if #(.NWORDS(NWORDS)) u_host (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .xfer_go    (xfer_go),
        .e_q        (e_q),
        .ctrl       (ctrl),
        .e_we       (e_we),
        .e_widx     (e_widx),
        .e_hi       (e_hi),
        .e_wdata    (e_wdata)
    );

    cs_ebuf #(.NWORDS(NWORDS)) u_ebuf (
        .clk   (clk),
        .rst   (rst),
        .we    (e_we),
        .wr_ok (wr_ok),
        .widx  (e_widx),
        .hi    (e_hi),
        .wdata (e_wdata),
        .e_q   (e_q)
    );

    cs_fbuf #(.NWORDS(NWORDS), .FRAME_W(FRAME_W)) u_fbuf (
        .clk        (clk),
        .rst        (rst),
        .blk_strobe (blk_strobe),
        .inhibit    (ctrl.inhibit),
        .e_q        (e_q),
        .frame_idx  (frame_idx),
        .xfer_go    (xfer_go),
        .cs_a       (cs_a),
        .cs_b       (cs_b)
    );

endmodule

// File: tb/tb_cs_dbuf.sv
`timescale 1ns/1ps
module tb_cs_dbuf;

    logic       clk = 1'b0;
    logic       rst, mclk_ok, host_wr, host_rd, blk_strobe;
    logic [6:0] host_addr;
    logic [7:0] host_wdata, host_rdata, frame_idx;
    logic       cs_a, cs_b;

    always #4 clk = ~clk;

    cs_dbuf dut (
        .clk(clk), .rst(rst), .mclk_ok(mclk_ok),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .blk_strobe(blk_strobe), .frame_idx(frame_idx),
        .cs_a(cs_a), .cs_b(cs_b)
    );

    localparam logic [6:0] A_CTRL = 7'h40;
    localparam logic [6:0] A_STAT = 7'h41;

    int   nchk = 0;
    int   nbad = 0;
    bit   done = 0;
    logic [7:0] exp_e [48];
    logic [7:0] exp_f [48];
    logic [7:0] rv;

    function automatic logic [7:0] pat1(input int i);
        return 8'((i * 29 + 7) & 255);
    endfunction

    function automatic logic [7:0] pat2(input int i);
        return 8'(((i * 53 + 145) ^ (i << 2)) & 255);
    endfunction

    task automatic chk(input int act, input int exp, input string req, input string what);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic strobe();
        @(negedge clk);
        blk_strobe = 1'b1;
        @(negedge clk);
        blk_strobe = 1'b0;
    endtask

    task automatic copy_model();
        for (int i = 0; i < 48; i++) exp_f[i] = exp_e[i];
    endtask

    task automatic read_all(input string req);
        logic [7:0] d;
        for (int i = 0; i < 48; i++) begin
            rd(7'(i), d);
            chk(d, exp_e[i], req, $sformatf("byte %0d", i));
        end
    endtask

    task automatic scan(input string req);
        logic ea, eb;
        for (int n = 0; n < 256; n++) begin
            frame_idx = 8'(n);
            #1;
            if (n < 192) begin
                ea = exp_f[2 * (n / 8)][n % 8];
                eb = exp_f[2 * (n / 8) + 1][n % 8];
            end else begin
                ea = 1'b0; eb = 1'b0;
            end
            chk(cs_a, ea, req, $sformatf("cs_a frame %0d", n));
            chk(cs_b, eb, req, $sformatf("cs_b frame %0d", n));
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            nchk++; nbad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; mclk_ok = 1'b1; host_wr = 1'b0; host_rd = 1'b0;
        host_addr = '0; host_wdata = '0; blk_strobe = 1'b0; frame_idx = '0;
        for (int i = 0; i < 48; i++) begin exp_e[i] = '0; exp_f[i] = '0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(A_CTRL, rv); chk(rv, 0, "R1", "ctrl after reset");
        rd(A_STAT, rv); chk(rv, 0, "R1", "status after reset");
        read_all("R1");
        scan("R1");

        // R2: byte mode fill and readback; R5: no copy before strobe
        for (int i = 0; i < 48; i++) begin
            wr(7'(i), pat1(i)); exp_e[i] = pat1(i);
        end
        read_all("R2");
        scan("R5");
        strobe(); copy_model();
        scan("R9");
        rd(A_STAT, rv); chk(rv, 1, "R7", "flag after copy");
        rd(A_STAT, rv); chk(rv, 0, "R7", "flag after clearing read");

        // R3: word mode
        wr(A_CTRL, 8'h02);
        rd(A_CTRL, rv); chk(rv, 2, "R11", "ctrl word mode");
        for (int k = 0; k < 24; k++) begin
            wr(7'(k), pat2(2 * k));     exp_e[2 * k]     = pat2(2 * k);
            wr(7'(k), pat2(2 * k + 1)); exp_e[2 * k + 1] = pat2(2 * k + 1);
        end
        for (int k = 0; k < 24; k++) begin
            rd(7'(k), rv); chk(rv, exp_e[2 * k],     "R3", $sformatf("word %0d upper", k));
            rd(7'(k), rv); chk(rv, exp_e[2 * k + 1], "R3", $sformatf("word %0d lower", k));
        end
        // half access then status read restarts at upper byte
        rd(7'(5), rv); chk(rv, exp_e[10], "R3", "word 5 upper");
        rd(A_STAT, rv);
        rd(7'(5), rv); chk(rv, exp_e[10], "R3", "restart upper after status");
        wr(A_CTRL, 8'h00);
        read_all("R3");

        // R6: inhibit holds the transmit copy and the flag
        wr(A_CTRL, 8'h01);
        strobe(); strobe();
        scan("R6");
        rd(A_STAT, rv); chk(rv, 0, "R6", "no flag while inhibited");
        wr(A_CTRL, 8'h00);
        strobe(); copy_model();
        scan("R5");

        // R4: power-down and missing clock drop writes
        wr(A_CTRL, 8'h04);
        rd(A_CTRL, rv); chk(rv, 4, "R11", "ctrl power-down");
        wr(7'(3), 8'hAA);
        rd(7'(3), rv); chk(rv, exp_e[3], "R4", "write while powered down");
        wr(A_CTRL, 8'h00);
        mclk_ok = 1'b0;
        wr(7'(5), 8'h3C);
        rd(7'(5), rv); chk(rv, exp_e[5], "R4", "write without master clock");
        mclk_ok = 1'b1;
        wr(7'(5), 8'h5A); exp_e[5] = 8'h5A;
        rd(7'(5), rv); chk(rv, 8'h5A, "R4", "write with clock back");

        // R10: write and strobe in the same cycle
        rd(A_STAT, rv);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 7'(0); host_wdata = 8'hC3; blk_strobe = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; blk_strobe = 1'b0;
        copy_model(); exp_e[0] = 8'hC3;
        scan("R10");
        rd(7'(0), rv); chk(rv, 8'hC3, "R10", "editable byte 0");
        strobe(); copy_model();
        scan("R10");

        // R8: completion and status read in the same cycle
        rd(A_STAT, rv); chk(rv, 1, "R7", "flag before collision");
        @(negedge clk);
        host_rd = 1'b1; host_addr = A_STAT; blk_strobe = 1'b1;
        @(negedge clk);
        host_rd = 1'b0; blk_strobe = 1'b0;
        chk(host_rdata, 0, "R8", "read during completion returns old flag");
        rd(A_STAT, rv); chk(rv, 1, "R8", "flag kept after collision");
        rd(A_STAT, rv); chk(rv, 0, "R7", "flag cleared");

        done = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule